// File: doc/BRIEF.md
# Clock Mode Controller with Delayed Status Confirmation

This block chooses which of three clock sources drives the clock output: the frequency-locked loop fed by a reference, the reference passed straight through (bypass), or the phase-locked loop output. Software programs three control registers over a byte-wide register bus. It then polls a read-only status register until the status shows that each change has taken effect. No status bit follows its control bit at once. Each confirmation arrives a fixed number of cycles (`SYNC_DLY`) after the write. The PLL lock flag rises only after the PLL has run undisturbed for `LOCK_CYC` cycles.

The oscillators and both loops are modelled, not built. The block reports which loop is enabled through `fll_en` and `pll_en`. It derives an operating-mode code from the control settings. A low-power bit shuts down both loops while the output is bypassed. Divider, multiplier and PLL-select writes are still stored in that state, so a later switch to the PLL can be set up ahead of time.

Top module: `clkmode_ctl`

## Requirements
- R1: After reset the registers read as follows: control 1 = 0x04, control 2 = 0x00, control 3 = 0x00, status = 0x10. The mode is 0, `fll_en`=1 and `pll_en`=0.
- R2: The register addresses are: 0 = control 1, 1 = control 2, 2 = control 3, 3 = status.
  - Control 1 stores all 8 bits: source select [7:6], reference divider [5:3], reference select [2] (0 = external), spare [1:0].
  - Control 2 stores only the low-power bit [3].
  - Control 3 stores only the PLL select [6] and the multiplier [3:0].
  - Unimplemented bits read 0.
- R3: Writes to the status address change no register. Reading any register has no side effect. Status bits 7, 1 and 0 always read 0.
- R4: Status bit 4 (reference status) takes the value of control 1 bit 2 exactly `SYNC_DLY` cycles after the write edge.
- R5: Status bits [3:2] (output-source status) take their new value exactly `SYNC_DLY` cycles after the write edge. The codes are:
  - 10 when the source select is 10 or 11 (bypass);
  - 01 when the source select is 01;
  - 00 when the source select is 00 with the PLL deselected;
  - 11 when the source select is 00 with the PLL selected.
- R6: Status bit 5 (PLL-select status) takes the value of control 3 bit 6 exactly `SYNC_DLY` cycles after the write edge.
- R7: Status bit 6 (lock) sets exactly `LOCK_CYC` cycles after the write that enabled the PLL or last disturbed it.
- R8: Lock clears in the same cycle as any of these writes: one that deselects the PLL, one that disables it through low power, or one that changes the divider or the multiplier. Rewriting the divider or multiplier with its current value keeps lock.
- R9: `pll_en` = PLL select AND NOT low-power-gate. `fll_en` = NOT PLL select AND NOT low-power-gate. The low-power gate is the low-power bit set while the source select is not 00. While gated, writes to the divider, the PLL select and the multiplier are still stored.
- R10: `clk_mode` follows the control settings in the same cycle as the write:
  - Source select 00: PLL selected gives 7 (PLL engaged, PEE). PLL deselected gives 0 (FLL on internal reference, FEI) with reference select 1, or 1 (FLL on external reference, FEE) with reference select 0.
  - Source select 01: low power gives 3 (internal bypass, low power, BLPI), otherwise 2 (internal bypass, FBI).
  - Source select 1x: low power gives 5 (external bypass, low power, BLPE); PLL selected gives 6 (PLL bypassed, external, PBE); otherwise 4 (FLL bypassed, external, FBE).
- R11: `fll_en` and `pll_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Write when set with reg_sel |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| fll_en | output | 1 | FLL enabled |
| pll_en | output | 1 | PLL enabled |
| clk_mode | output | 3 | Derived operating-mode code |

## Verification
The bench walks the full bring-up sequence from FLL on the internal reference (mode 0), through external bypass (4), external bypass in low power (5) and PLL bypassed (6), to PLL engaged (7). It samples status one cycle before and exactly at each confirmation point. A status path that was one stage short or one stage long would therefore fail the check.

It disturbs a locked PLL in each of the following ways:
- a multiplier change;
- a divider change;
- entering low power while bypassed;
- deselecting the PLL.

A design that kept lock, or cleared it a cycle late, reads the wrong bit 6 right after the write. Writing the same divider or multiplier value, and entering low power while the PLL drives the output, must both keep lock. A controller that restarted lock on any write would fail there. Writes made while in low power must still be stored, and a status-address write must change nothing.

// File: rtl/clkmode_ctl.sv
module clkmode_ctl #(
  parameter int SYNC_DLY = 4,
  parameter int LOCK_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       fll_en,
  output logic       pll_en,
  output logic [2:0] clk_mode
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);

  logic [1:0] src_q, spare_q;
  logic [2:0] rdiv_q;
  logic       irefs_q, lp_q, plls_q, lock_q;
  logic [3:0] vdiv_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0] sync_pipe [SYNC_DLY];
  logic [3:0] tgt, stat;

  wire wr_c1 = reg_sel & reg_wr & (reg_addr == 2'd0);
  wire wr_c2 = reg_sel & reg_wr & (reg_addr == 2'd1);
  wire wr_c3 = reg_sel & reg_wr & (reg_addr == 2'd2);

  wire [1:0] src_n  = wr_c1 ? reg_wdata[7:6] : src_q;
  wire       lp_n   = wr_c2 ? reg_wdata[3]   : lp_q;
  wire       plls_n = wr_c3 ? reg_wdata[6]   : plls_q;
  wire       pll_on_n = plls_n & ~(lp_n & (src_n != 2'b00));

  wire lp_gate = lp_q & (src_q != 2'b00);
  assign pll_en = plls_q & ~lp_gate;
  assign fll_en = ~plls_q & ~lp_gate;

  wire kill = ~pll_en | ~pll_on_n
            | (wr_c1 & (reg_wdata[5:3] != rdiv_q))
            | (wr_c3 & (reg_wdata[3:0] != vdiv_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 2'b00; rdiv_q <= 3'd0; irefs_q <= 1'b1; spare_q <= 2'b00;
      lp_q <= 1'b0; plls_q <= 1'b0; vdiv_q <= 4'd0;
    end else begin
      if (wr_c1) {src_q, rdiv_q, irefs_q, spare_q} <= reg_wdata;
      if (wr_c2) lp_q <= reg_wdata[3];
      if (wr_c3) begin
        plls_q <= reg_wdata[6];
        vdiv_q <= reg_wdata[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; lock_q <= 1'b0;
    end else if (kill) begin
      cnt_q <= '0; lock_q <= 1'b0;
    end else if (!lock_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(LOCK_CYC - 1)) lock_q <= 1'b1;
    end
  end

  always_comb begin
    tgt[3] = plls_q;
    tgt[2] = irefs_q;
    case (src_q)
      2'b00:   tgt[1:0] = plls_q ? 2'b11 : 2'b00;
      2'b01:   tgt[1:0] = 2'b01;
      default: tgt[1:0] = 2'b10;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_DLY; i++) sync_pipe[i] <= 4'b0100;
    end else begin
      sync_pipe[0] <= tgt;
      for (int i = 1; i < SYNC_DLY; i++) sync_pipe[i] <= sync_pipe[i-1];
    end
  end
  assign stat = sync_pipe[SYNC_DLY-1];

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {src_q, rdiv_q, irefs_q, spare_q};
      2'd1:    reg_rdata = {4'b0, lp_q, 3'b0};
      2'd2:    reg_rdata = {1'b0, plls_q, 2'b0, vdiv_q};
      default: reg_rdata = {1'b0, lock_q, stat[3], stat[2], stat[1:0], 2'b00};
    endcase
  end

  always_comb begin
    case (src_q)
      2'b00:   clk_mode = plls_q ? 3'd7 : (irefs_q ? 3'd0 : 3'd1);
      2'b01:   clk_mode = lp_q ? 3'd3 : 3'd2;
      default: clk_mode = lp_q ? 3'd5 : (plls_q ? 3'd6 : 3'd4);
    endcase
  end
endmodule

module clkmode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       fll_en,
  input logic       pll_en,
  input logic [2:0] clk_mode,
  input logic       lock,
  input logic       lp,
  input logic [1:0] src
);
  p_loops_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fll_en && pll_en));
  p_lp_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lp && src != 2'b00) |-> (!fll_en && !pll_en));
  p_lock_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> !lock);
  p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(pll_en));
  p_stat_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata[7] == 1'b0 && reg_rdata[1:0] == 2'b00));
  p_pee_pll_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_mode == 3'd7) |-> pll_en);
endmodule

bind clkmode_ctl clkmode_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .fll_en(fll_en), .pll_en(pll_en), .clk_mode(clk_mode),
  .lock(lock_q), .lp(lp_q), .src(src_q)
);

// File: tb/clkmode_ctl_tb.sv
`timescale 1ns/1ps
module clkmode_ctl_tb;
  localparam int D = 4;
  localparam int L = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic fll_en, pll_en;
  logic [2:0] clk_mode;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  clkmode_ctl #(.SYNC_DLY(D), .LOCK_CYC(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fll_en(fll_en), .pll_en(pll_en), .clk_mode(clk_mode));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic exp_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic lag(input int n, input logic [7:0] old_v, input logic [7:0] new_v, input string tag);
    repeat (n - 1) @(negedge clk);
    exp_reg(2'd3, old_v, {tag, " before"});
    @(negedge clk);
    exp_reg(2'd3, new_v, {tag, " at"});
  endtask

  task automatic t_reset;
    exp_reg(2'd0, 8'h04, "R1 ctrl1");
    exp_reg(2'd1, 8'h00, "R1 ctrl2");
    exp_reg(2'd2, 8'h00, "R1 ctrl3");
    exp_reg(2'd3, 8'h10, "R1 status");
    chk(clk_mode == 3'd0, "R1 mode", clk_mode, 0);
    chk(fll_en && !pll_en, "R1 enables", {fll_en, pll_en}, 2'b10);
  endtask

  task automatic t_fbe;
    wr(2'd0, 8'hB8);
    chk(clk_mode == 3'd4, "R10 FBE", clk_mode, 4);
    lag(D, 8'h10, 8'h08, "R4 R5 ext bypass");
  endtask

  task automatic t_blpe;
    wr(2'd1, 8'h08);
    chk(clk_mode == 3'd5, "R10 BLPE", clk_mode, 5);
    chk(!fll_en && !pll_en, "R9 lp gate", {fll_en, pll_en}, 0);
    wr(2'd0, 8'h90);
    wr(2'd2, 8'h44);
    exp_reg(2'd0, 8'h90, "R9 divider stored");
    exp_reg(2'd2, 8'h44, "R9 pll sel stored");
    chk(!pll_en && clk_mode == 3'd5, "R9 pll held off", {pll_en, clk_mode}, 5);
    lag(D, 8'h08, 8'h28, "R6 pll sel status");
  endtask

  task automatic t_pbe;
    wr(2'd1, 8'h00);
    chk(clk_mode == 3'd6 && pll_en, "R10 PBE", {pll_en, clk_mode}, 4'hE);
    lag(L, 8'h28, 8'h68, "R7 lock");
    wr(2'd1, 8'h08);
    exp_reg(2'd3, 8'h28, "R8 lp drops lock");
    wr(2'd1, 8'h00);
    lag(L, 8'h28, 8'h68, "R7 relock after lp");
  endtask

  task automatic t_pee;
    wr(2'd0, 8'h10);
    chk(clk_mode == 3'd7, "R10 PEE", clk_mode, 7);
    exp_reg(2'd3, 8'h68, "R8 same divider keeps lock");
    lag(D, 8'h68, 8'h6C, "R5 pll drives out");
    wr(2'd2, 8'h45);
    exp_reg(2'd3, 8'h2C, "R8 multiplier change");
    lag(L, 8'h2C, 8'h6C, "R7 relock mult");
    wr(2'd2, 8'h45);
    exp_reg(2'd3, 8'h6C, "R8 same multiplier keeps lock");
    wr(2'd0, 8'h18);
    exp_reg(2'd3, 8'h2C, "R8 divider change");
    lag(L, 8'h2C, 8'h6C, "R7 relock div");
    wr(2'd1, 8'h08);
    chk(pll_en && clk_mode == 3'd7, "R9 lp ignored in PEE", {pll_en, clk_mode}, 4'hF);
    exp_reg(2'd3, 8'h6C, "R9 lock kept in PEE lp");
    wr(2'd1, 8'h00);
  endtask

  task automatic t_fee;
    wr(2'd2, 8'h04);
    chk(clk_mode == 3'd1, "R10 FEE", clk_mode, 1);
    chk(fll_en && !pll_en, "R11 fll on", {fll_en, pll_en}, 2'b10);
    exp_reg(2'd3, 8'h2C, "R8 deselect drops lock");
    lag(D, 8'h2C, 8'h00, "R5 R6 fll out");
  endtask

  task automatic t_fbi;
    wr(2'd0, 8'h44);
    chk(clk_mode == 3'd2, "R10 FBI", clk_mode, 2);
    lag(D, 8'h00, 8'h14, "R4 R5 int bypass");
    wr(2'd1, 8'h08);
    chk(clk_mode == 3'd3 && !fll_en, "R10 R9 BLPI", {fll_en, clk_mode}, 3);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_regs;
    wr(2'd3, 8'hFF);
    repeat (D + 1) @(negedge clk);
    exp_reg(2'd3, 8'h14, "R3 status write ignored");
    exp_reg(2'd3, 8'h14, "R3 reread same");
    exp_reg(2'd0, 8'h44, "R3 ctrl1 untouched");
    exp_reg(2'd1, 8'h00, "R3 ctrl2 untouched");
    exp_reg(2'd2, 8'h04, "R3 ctrl3 untouched");
    wr(2'd1, 8'hFF);
    exp_reg(2'd1, 8'h08, "R2 ctrl2 mask");
    wr(2'd2, 8'hFF);
    exp_reg(2'd2, 8'h4F, "R2 ctrl3 mask");
    wr(2'd0, 8'hA7);
    exp_reg(2'd0, 8'hA7, "R2 ctrl1 full");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fbe;
    t_blpe;
    t_pbe;
    t_pee;
    t_fee;
    t_fbi;
    t_regs;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule